// File: doc/BRIEF.md
# Burstless Egress Rate Limiter

This block caps the transmit rate of one egress port without granting any burst credit. A fill counter holds the amount of traffic sent but not yet paid for. Each completed frame adds its measured size to the counter. A step timer subtracts a programmed decrement from the counter once per programmed number of clock cycles. A new frame is granted only while the counter is empty, so the port never sends faster than the drain rate. With a 16 ns clock, a decrement of D per step of P cycles gives a rate of 8·D/(16 ns·P) bits per second. Steps of 7812, 500, 50 and 5 cycles give granularities of 64 kbps, 1 Mbps, 10 Mbps and 100 Mbps.

Software programs two 16-bit control words through a write port. Frame sizes can be counted as whole frames, or as bytes at layer 1, 2 or 3. Each byte count is taken from its own length input. A per-frame overhead in 4-byte units can be added to the byte count, which lowers the effective rate. The transmit path asks for a frame with a request, receives a one-cycle grant, and signals the end of the frame with a done pulse.

Top module: `egress_shaper`

## Requirements
- R1: After reset, control word 1 reads as decrement 1 with overhead 0, and control word 2 reads as frame mode with step 0. A pending request is therefore granted in the same cycle it is raised.
- R2: A write with `cfg_sel_i`=0 loads control word 1: bits 7:0 set the decrement and bits 11:8 set the overhead in 4-byte units. A write with `cfg_sel_i`=1 loads control word 2: bits 15:14 set the count mode and bits 13:0 set the step period in cycles.
- R3: While the step is 0, limiting is off. The fill counter is held at zero, and an idle request is granted combinationally every time.
- R4: At most one frame is outstanding. After a grant, no further grant occurs until a done pulse. A done pulse while no frame is outstanding has no effect.
- R5: While the step is nonzero, a grant occurs exactly when the block is idle, a request is present and the fill counter is zero.
- R6: In frame mode (count mode 00), each completed frame adds exactly 1 to the counter, and the overhead field is ignored.
- R7: Count modes 01, 10 and 11 add the L1, L2 or L3 length input, respectively, plus 4 times the overhead. The value used is the one present at grant, and it is added on the done pulse.
- R8: Every step period, the decrement is subtracted from the counter, which stops at zero. A write to control word 2 restarts the step timer.
- R9: There is no burst allowance. After a frame of size S completes, the next grant comes after exactly ceil(S/D) further step expiries. Each frame of a back-to-back stream pays this full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (16 ns nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_sel_i | input | 1 | 0 selects control word 1, 1 selects control word 2 |
| cfg_data_i | input | 16 | Control word write data |
| req_i | input | 1 | Frame ready to start |
| len_l1_i | input | LEN_W | Frame length in layer-1 bytes |
| len_l2_i | input | LEN_W | Frame length in layer-2 bytes |
| len_l3_i | input | LEN_W | Frame length in layer-3 bytes |
| grant_o | output | 1 | One-cycle permission to start the frame |
| tx_done_i | input | 1 | Pulse at the end of the granted frame |

## Verification
The hardest situation to reach is the exact moment the counter drains to zero. That moment depends on the phase of the step timer when the frame completes, and it can take thousands of cycles at the long step codes. Directed runs program the control words and hold a request high. They then measure the number of cycles from the done pulse to the next grant and compare it against the window that ceil(S/D) step periods allows. Frame lengths on the unselected inputs are chosen so that using the wrong input falls outside the window. Long random runs mix control writes, idle done pulses and changing lengths, and compare the grant with a bench model every cycle.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
  typedef enum logic [1:0] {
    CNT_FRAMES = 2'b00,
    CNT_L1     = 2'b01,
    CNT_L2     = 2'b10,
    CNT_L3     = 2'b11
  } cnt_mode_e;

  localparam int unsigned CFG_W    = 16;
  localparam int unsigned OVH_LSB  = 8;
  localparam int unsigned MODE_LSB = 14;
endpackage

// File: rtl/shaper_step_timer.sv
module shaper_step_timer #(
  parameter int unsigned STEP_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  input  logic              restart_i,
  output logic              expire_o
);
  logic [STEP_W-1:0] cnt_q;

  assign expire_o = (step_i != '0) && (cnt_q >= step_i - STEP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        cnt_q <= '0;
    else if (restart_i || step_i == '0 || expire_o)    cnt_q <= '0;
    else                                                cnt_q <= cnt_q + STEP_W'(1);
  end

  p_timer_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == '0);
endmodule

// File: rtl/shaper_size_calc.sv
module shaper_size_calc
  import shaper_pkg::*;
#(
  parameter int unsigned LEN_W  = 14,
  parameter int unsigned OVH_W  = 4,
  parameter int unsigned SIZE_W = LEN_W + 1
) (
  input  cnt_mode_e         mode_i,
  input  logic [LEN_W-1:0]  len_l1_i,
  input  logic [LEN_W-1:0]  len_l2_i,
  input  logic [LEN_W-1:0]  len_l3_i,
  input  logic [OVH_W-1:0]  ovh_i,
  output logic [SIZE_W-1:0] size_o
);
  logic [LEN_W-1:0]  len_sel;
  logic [SIZE_W-1:0] ovh_bytes;

  assign ovh_bytes = SIZE_W'(ovh_i) << 2;

  always_comb begin
    unique case (mode_i)
      CNT_L1:  len_sel = len_l1_i;
      CNT_L2:  len_sel = len_l2_i;
      CNT_L3:  len_sel = len_l3_i;
      default: len_sel = '0;
    endcase
  end

  assign size_o = (mode_i == CNT_FRAMES) ? SIZE_W'(1) : SIZE_W'(len_sel) + ovh_bytes;
endmodule

// File: rtl/shaper_fill.sv
module shaper_fill #(
  parameter int unsigned FILL_W = 15,
  parameter int unsigned DEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              dec_en_i,
  input  logic [DEC_W-1:0]  dec_i,
  input  logic              add_en_i,
  input  logic [FILL_W-1:0] add_i,
  output logic              empty_o
);
  logic [FILL_W-1:0] fill_q, sub, fill_d;
  logic [FILL_W:0]   sum;

  always_comb begin
    sub = fill_q;
    if (dec_en_i) sub = (fill_q > FILL_W'(dec_i)) ? fill_q - FILL_W'(dec_i) : '0;
    sum = {1'b0, sub} + {1'b0, (add_en_i ? add_i : '0)};
    if (clr_i)             fill_d = '0;
    else if (sum[FILL_W])  fill_d = '1;
    else                   fill_d = sum[FILL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= fill_d;
  end

  assign empty_o = (fill_q == '0);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !dec_en_i && !add_en_i) |=> $stable(fill_q));
  p_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_en_i && !add_en_i && !clr_i && fill_q != '0 && dec_i != '0) |=> fill_q < $past(fill_q));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> fill_q == '0);
endmodule

// File: rtl/egress_shaper.sv
module egress_shaper
  import shaper_pkg::*;
#(
  parameter int unsigned LEN_W  = 14,
  parameter int unsigned DEC_W  = 8,
  parameter int unsigned OVH_W  = 4,
  parameter int unsigned STEP_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [15:0]      cfg_data_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_l1_i,
  input  logic [LEN_W-1:0] len_l2_i,
  input  logic [LEN_W-1:0] len_l3_i,
  output logic             grant_o,
  input  logic             tx_done_i
);
  // frame size never exceeds max length + 60, so this width cannot saturate
  localparam int unsigned SIZE_W = LEN_W + 1;

  logic [DEC_W-1:0]  dec_q;
  logic [OVH_W-1:0]  ovh_q;
  cnt_mode_e         mode_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q, bypass, empty, expire, restart;
  logic [SIZE_W-1:0] size_now, size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q  <= DEC_W'(1);
      ovh_q  <= '0;
      mode_q <= CNT_FRAMES;
      step_q <= '0;
    end else if (cfg_we_i) begin
      if (!cfg_sel_i) begin
        dec_q <= cfg_data_i[DEC_W-1:0];
        ovh_q <= cfg_data_i[OVH_LSB +: OVH_W];
      end else begin
        mode_q <= cnt_mode_e'(cfg_data_i[MODE_LSB +: 2]);
        step_q <= cfg_data_i[STEP_W-1:0];
      end
    end
  end

  assign restart = cfg_we_i && cfg_sel_i;
  assign bypass  = (step_q == '0);
  assign grant_o = !busy_q && req_i && (bypass || empty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      size_q <= '0;
    end else if (grant_o) begin
      busy_q <= 1'b1;
      size_q <= size_now;
    end else if (tx_done_i) begin
      busy_q <= 1'b0;
    end
  end

  shaper_step_timer #(.STEP_W(STEP_W)) u_timer (
    .clk_i, .rst_ni, .step_i(step_q), .restart_i(restart), .expire_o(expire)
  );

  shaper_size_calc #(.LEN_W(LEN_W), .OVH_W(OVH_W), .SIZE_W(SIZE_W)) u_size (
    .mode_i(mode_q), .len_l1_i, .len_l2_i, .len_l3_i, .ovh_i(ovh_q), .size_o(size_now)
  );

  shaper_fill #(.FILL_W(SIZE_W), .DEC_W(DEC_W)) u_fill (
    .clk_i, .rst_ni, .clr_i(bypass), .dec_en_i(expire), .dec_i(dec_q),
    .add_en_i(busy_q && tx_done_i), .add_i(size_q), .empty_o(empty)
  );

  p_one_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
  p_hold_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !tx_done_i) |=> !grant_o);
  p_frame_size_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && mode_q == CNT_FRAMES) |=> size_q == SIZE_W'(1));
  p_grant_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !bypass) |-> empty);
endmodule

// File: tb/sim_egress_shaper.sv
`timescale 1ns/1ps
module sim_egress_shaper;
  localparam int LEN_W = 14;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, req = 1'b0, tx_done = 1'b0, grant;
  logic [15:0] cfg_data = '0;
  logic [LEN_W-1:0] l1 = '0, l2 = '0, l3 = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  egress_shaper u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_data_i(cfg_data), .req_i(req), .len_l1_i(l1), .len_l2_i(l2),
    .len_l3_i(l3), .grant_o(grant), .tx_done_i(tx_done)
  );

  // spec model of the requirements
  int m_dec, m_ovh, m_mode, m_step, m_tmr, m_fill, m_size;
  bit m_busy;

  function automatic int frame_size(int mode, int ovh, int a, int b, int c);
    if (mode == 0) return 1;
    return ((mode == 1) ? a : (mode == 2) ? b : c) + 4 * ovh;
  endfunction

  always @(negedge clk) begin
    if (!rst_ni) begin
      m_dec = 1; m_ovh = 0; m_mode = 0; m_step = 0; m_tmr = 0; m_fill = 0;
      m_busy = 0; m_size = 0;
    end else begin
      bit exp_g, expire;
      int f;
      exp_g = !m_busy && req && (m_step == 0 || m_fill == 0);
      checks++;
      if (grant !== exp_g) begin
        errors++;
        $display("FAIL %s grant act=%0b exp=%0b t=%0t",
                 (m_step == 0) ? "R3" : m_busy ? "R4" : "R5", grant, exp_g, $time);
      end
      expire = (m_step != 0) && (m_tmr >= m_step - 1);
      f = m_fill;
      if (expire) f = (f > m_dec) ? f - m_dec : 0;
      if (m_busy && tx_done) f = f + m_size;
      if (m_step == 0) f = 0;
      m_fill = f;
      if ((cfg_we && cfg_sel) || m_step == 0 || expire) m_tmr = 0; else m_tmr++;
      if (exp_g) begin
        m_busy = 1;
        m_size = frame_size(m_mode, m_ovh, int'(l1), int'(l2), int'(l3));
      end else if (tx_done) m_busy = 0;
      if (cfg_we) begin
        if (!cfg_sel) begin m_dec = cfg_data[7:0]; m_ovh = cfg_data[11:8]; end
        else begin m_mode = cfg_data[15:14]; m_step = cfg_data[13:0]; end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    step(); cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    step(); cfg_we = 1'b0;
  endtask

  task automatic settle();
    req = 1'b0;
    step();
    if (m_busy) begin tx_done = 1'b1; step(); tx_done = 1'b0; end
    for (int i = 0; i < 20000 && m_fill != 0; i++) step();
  endtask

  task automatic check_range(input string tag, input int n, input int lo, input int hi);
    checks++;
    if (n < lo || n > hi) begin
      errors++;
      $display("FAIL %s cycles done->grant act=%0d exp=%0d..%0d", tag, n, lo, hi);
    end
  endtask

  // grant a frame, finish it, count negedges until the next grant
  task automatic measure(input string tag, input int lo, input int hi);
    int n;
    settle();
    req = 1'b1;
    for (int i = 0; i < 20000; i++) begin @(negedge clk); if (grant) break; end
    step(); tx_done = 1'b1;
    step(); tx_done = 1'b0;
    n = 0;
    for (int i = 0; i < 20000; i++) begin @(negedge clk); n++; if (grant) break; end
    check_range(tag, n, lo, hi);
    step(); req = 1'b0;
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1: unlimited after reset
    step(); req = 1'b1;
    @(negedge clk);
    checks++;
    if (grant !== 1'b1) begin errors++; $display("FAIL R1 grant act=%0b exp=1", grant); end
    settle();
    // R6: frame mode counts 1, overhead ignored (ovh 15, dec 1, step 5)
    l1 = 1000; l2 = 1000; l3 = 1000;
    wr(0, 16'h0F01); wr(1, 16'd5);
    measure("R6", 1, 5);
    // R2/R7: L2, ovh 2 (8 B), dec 4, step 5: S=28, k=7
    l1 = 3000; l2 = 20; l3 = 7;
    wr(0, 16'h0204); wr(1, 16'h8005);
    measure("R7", 31, 35);
    // R7: L1, dec 7, step 50: S=100, k=15
    l1 = 100; l2 = 300; l3 = 20;
    wr(0, 16'h0007); wr(1, 16'h4000 | 16'd50);
    measure("R7", 701, 750);
    // R2/R7: L3, ovh 15 (60 B), dec 10, step 500: S=100, k=10
    l1 = 2000; l2 = 2000; l3 = 40;
    wr(0, 16'h0F0A); wr(1, 16'hC000 | 16'd500);
    measure("R2", 4501, 5000);
    // R8: decrement larger than fill stops at zero
    l2 = 20;
    wr(0, 16'h00C8); wr(1, 16'h8005);
    measure("R8", 1, 5);
    // R9: back-to-back frames each pay full delay: S=40, D=4, k=10
    l2 = 40;
    wr(0, 16'h0004); wr(1, 16'h8005);
    measure("R9", 46, 50);
    measure("R9", 46, 50);
    // R3: step 0 disables limiting
    wr(1, 16'h8000);
    measure("R3", 1, 1);
    // R4: done while idle is ignored
    wr(0, 16'h0001); wr(1, 16'd500);
    settle();
    tx_done = 1'b1; step(); tx_done = 1'b0; req = 1'b1;
    @(negedge clk);
    checks++;
    if (grant !== 1'b1) begin errors++; $display("FAIL R4 grant after idle done act=%0b exp=1", grant); end
    settle();
    // random mix
    for (int i = 0; i < 30000; i++) begin
      int r, s;
      step();
      r = $urandom;
      cfg_we = (r % 97) == 0;
      cfg_sel = r[8];
      s = r[11:9];
      if (!r[8]) cfg_data = {4'h0, 4'($urandom), 8'($urandom % 64)};
      else cfg_data = {2'($urandom),
                       14'((s == 0) ? 0 : (s == 1) ? 5 : (s == 2) ? 50 : (s == 3) ? 500 :
                           (s == 4) ? 7812 : 1 + $urandom % 20)};
      req = ($urandom % 10) < 7;
      tx_done = ($urandom % 10) < 3;
      l1 = LEN_W'($urandom % 300); l2 = LEN_W'($urandom % 300); l3 = LEN_W'($urandom % 300);
    end
    settle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 4);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule